// File: doc/BRIEF.md
# Two-Read One-Write Register File with Mirrored Banks

This block is the integer register file of a simple processor datapath. It serves two source-operand reads and one destination write in a single clock cycle. The storage is split into two banks, and each bank can answer only one read address. Every write is applied to both banks on the same clock edge, so the two banks always hold the same contents. The first read port is answered only by the first bank, and the second read port only by the second bank.

Reads are combinational from the address. A write commits on the rising clock edge. The write can target the same register that a read port is asking for in that cycle. In that case a forwarding multiplexer on the read port returns the incoming write data, so the reader sees the new value without waiting a cycle. Register zero is hard-wired to zero.

The number of registers is a parameter. The default of 32 suits the full base integer register set, and 16 suits the reduced embedded set. On reset, every entry is loaded with a recognisable poison word rather than zero. A value read from a register that was never written therefore stands out.

Top module: `dual_bank_regfile`

## Requirements
- R1: While reset is low and the clock runs, every register from 1 to NUM_REGS-1 is loaded with the poison word FILL (default 0xDEADBEEF). After reset is released, both read ports return FILL for any such register until it is written.
- R2: Read address 0 always returns zero on either port. A write to address 0 has no effect and is never forwarded.
- R3: When wr_en is high on a rising edge, wr_data is stored at wr_addr (nonzero). From the next cycle on, both read ports return it for that address.
- R4: When wr_en is low, the stored contents do not change, and a read address equal to wr_addr returns the stored value, not wr_data.
- R5: When wr_en is high, wr_addr is nonzero, and a read port's address equals wr_addr in the same cycle, that port returns wr_data combinationally.
- R6: Both read ports may name the same register in the same cycle, and they then return identical data. This data shows that the two banks hold the same contents.
- R7: The two read ports are independent: in one cycle they return the values of two different registers, each matching its own address.
- R8: The register count is set by NUM_REGS, and the address width is clog2(NUM_REGS). A 16-register instance stores and returns every register from 1 to 15 correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low reset; loads the poison word into every register while low and the clock runs |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Destination register index |
| wr_data | input | DATA_W | Data to write |
| rd_a_addr | input | AW | First source register index |
| rd_a_data | output | DATA_W | First source data (served by bank A) |
| rd_b_addr | input | AW | Second source register index |
| rd_b_data | output | DATA_W | Second source data (served by bank B) |

## Verification
Each bank can be seen only through its own read port. If the two banks diverge, the two ports return different data when they name the same register. This mismatch appears in the same cycle as the read, one clock after the write that caused it. The sweeps therefore read every register through both ports at once, with the same address on each port, and also with different addresses on each port. A broken forwarding path, or a write that lands in the wrong bank or at the wrong index, shows as a mismatch against the bench's reference array. That mismatch appears either in the colliding cycle itself or on the first readback after the write. A poison word seen where written data was expected points to a write that was dropped.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int unsigned RD_PORTS = 2;
    localparam logic [31:0] POISON_WORD = 32'hDEADBEEF;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned AW       = $clog2(NUM_REGS),
    parameter logic [DATA_W-1:0] FILL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (wr_addr != '0)) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= {NUM_REGS{FILL}};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AW     = 5
) (
    input  logic [AW-1:0]     rd_addr,
    input  logic [DATA_W-1:0] stored_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic is_zero;
    logic collide;

    always_comb begin
        is_zero = (rd_addr == '0);
        collide = wr_en && (wr_addr == rd_addr);
        if (is_zero) begin
            rd_data = '0;
        end else if (collide) begin
            rd_data = wr_data;
        end else begin
            rd_data = stored_data;
        end
    end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned AW       = $clog2(NUM_REGS),
    parameter logic [DATA_W-1:0] FILL = DATA_W'(regfile_pkg::POISON_WORD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int unsigned NP = regfile_pkg::RD_PORTS;

    logic [AW-1:0]     port_addr   [NP];
    logic [DATA_W-1:0] port_stored [NP];
    logic [DATA_W-1:0] port_data   [NP];

    assign port_addr[0] = rd_a_addr;
    assign port_addr[1] = rd_b_addr;
    assign rd_a_data    = port_data[0];
    assign rd_b_data    = port_data[1];

    for (genvar p = 0; p < NP; p++) begin : g_port
        rf_bank #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .AW       (AW),
            .FILL     (FILL)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (port_addr[p]),
            .rd_data (port_stored[p])
        );

        rf_bypass #(
            .DATA_W (DATA_W),
            .AW     (AW)
        ) u_fwd (
            .rd_addr     (port_addr[p]),
            .stored_data (port_stored[p]),
            .wr_en       (wr_en),
            .wr_addr     (wr_addr),
            .wr_data     (wr_data),
            .rd_data     (port_data[p])
        );
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [AW-1:0]     rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [AW-1:0]     rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0));
    p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

    p_fwd_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && wr_addr == rd_a_addr) |-> (rd_a_data == wr_data));
    p_fwd_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && wr_addr == rd_b_addr) |-> (rd_b_data == wr_data));

    p_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));

    p_store_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(wr_en) && $past(wr_addr) != '0 && rd_a_addr == $past(wr_addr)
         && !(wr_en && wr_addr == rd_a_addr)) |-> (rd_a_data == $past(wr_data)));

    p_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(wr_en) && $stable(rd_b_addr)
         && !(wr_en && wr_addr == rd_b_addr)) |-> $stable(rd_b_data));
endmodule

bind dual_bank_regfile rf_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data)
);

// File: tb/dual_bank_regfile_test.sv
module dual_bank_regfile_test;
    localparam logic [31:0] FILL = 32'hDEADBEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_a_addr = '0;
    logic [4:0]  rd_b_addr = '0;
    logic [31:0] rd_a_data, rd_b_data;

    logic        s_wr_en = 1'b0;
    logic [3:0]  s_wr_addr = '0;
    logic [31:0] s_wr_data = '0;
    logic [3:0]  s_rd_a_addr = '0;
    logic [3:0]  s_rd_b_addr = '0;
    logic [31:0] s_rd_a_data, s_rd_b_data;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [32];

    always #5 clk = ~clk;

    dual_bank_regfile uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data));

    dual_bank_regfile #(.NUM_REGS(16)) uut_small (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
        .rd_a_addr(s_rd_a_addr), .rd_a_data(s_rd_a_data),
        .rd_b_addr(s_rd_b_addr), .rd_b_data(s_rd_b_data));

    function automatic logic [31:0] pattern(input int r, input int salt);
        return (32'h0101_0101 * r) ^ (32'h3C00_0000 + salt * 32'h0001_0003);
    endfunction

    function automatic logic [31:0] expect_rd(input logic [4:0] a);
        if (a == 0) return 32'h0;
        if (wr_en && wr_addr == a) return wr_data;
        return model[a];
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic drive(input logic we, input int wa, input logic [31:0] wd,
                         input int ra, input int rb);
        @(negedge clk);
        wr_en = we; wr_addr = 5'(wa); wr_data = wd;
        rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
        #1;
    endtask

    task automatic commit();
        if (wr_en && wr_addr != 0) model[wr_addr] = wr_data;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = FILL;
        model[0] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: poison after reset, register zero reads zero
        for (int r = 0; r < 32; r++) begin
            drive(1'b0, 0, 32'h0, r, r);
            check(r == 0 ? "R2" : "R1", rd_a_data, r == 0 ? 32'h0 : FILL);
            check(r == 0 ? "R2" : "R1", rd_b_data, r == 0 ? 32'h0 : FILL);
        end

        // R3: write every register, then read back on both ports
        for (int r = 1; r < 32; r++) begin
            drive(1'b1, r, pattern(r, 1), 0, 0);
            commit();
            drive(1'b0, 0, 32'h0, r, r);
            check("R3", rd_a_data, model[r]);
            check("R6", rd_b_data, model[r]);
        end

        // R7: independent addresses on the two ports
        for (int r = 0; r < 32; r++) begin
            drive(1'b0, 0, 32'h0, r, 31 - r);
            check("R7", rd_a_data, expect_rd(5'(r)));
            check("R7", rd_b_data, expect_rd(5'(31 - r)));
        end

        // R2: write to register zero is neither stored nor forwarded
        drive(1'b1, 0, 32'h1234_5678, 0, 0);
        check("R2", rd_a_data, 32'h0);
        check("R2", rd_b_data, 32'h0);
        drive(1'b0, 0, 32'h0, 0, 0);
        check("R2", rd_a_data, 32'h0);

        // R4: disabled write neither forwards nor stores
        drive(1'b0, 5, 32'hAAAA_5555, 5, 5);
        check("R4", rd_a_data, model[5]);
        check("R4", rd_b_data, model[5]);
        drive(1'b0, 0, 32'h0, 5, 5);
        check("R4", rd_a_data, model[5]);
        check("R4", rd_b_data, model[5]);

        // R5: same-cycle forwarding on each port, the other port reading a neighbour
        for (int r = 1; r < 32; r++) begin
            drive(1'b1, r, pattern(r, 7), r, (r + 1) % 32);
            check("R5", rd_a_data, wr_data);
            check("R5", rd_b_data, expect_rd(5'((r + 1) % 32)));
            commit();
            drive(1'b1, r, pattern(r, 9), (r + 3) % 32, r);
            check("R5", rd_b_data, wr_data);
            check("R5", rd_a_data, expect_rd(5'((r + 3) % 32)));
            commit();
            drive(1'b0, 0, 32'h0, r, r);
            check("R6", rd_a_data, model[r]);
            check("R6", rd_b_data, model[r]);
        end

        // R8: sixteen-register instance
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            s_wr_en = 1'b0; s_rd_a_addr = 4'(r); s_rd_b_addr = 4'(r);
            #1;
            check("R8", s_rd_a_data, r == 0 ? 32'h0 : FILL);
        end
        for (int r = 1; r < 16; r++) begin
            @(negedge clk);
            s_wr_en = 1'b1; s_wr_addr = 4'(r); s_wr_data = pattern(r, 21);
            s_rd_a_addr = 4'(r); s_rd_b_addr = 4'(16 - r);
            #1;
            check("R8", s_rd_a_data, pattern(r, 21));
        end
        @(negedge clk);
        s_wr_en = 1'b0;
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            s_rd_a_addr = 4'(r); s_rd_b_addr = 4'(15 - r);
            #1;
            check("R8", s_rd_a_data, r == 0 ? 32'h0 : pattern(r, 21));
            check("R8", s_rd_b_data, (15 - r) == 0 ? 32'h0 : pattern(15 - r, 21));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule